// File: doc/BRIEF.md
# Ladder Contact Matrix Evaluator

The block solves power flow through a ladder program laid out on a grid of contact cells. There are ROWS by COLS cells, 16 by 16 by default, numbered row-major. Each cell holds a contact, and the contact reads one bit of an input image. The contact can be normally open or normally closed. Each cell also carries a branch kind that lets current enter from the cell above, from the cell below, from both, or from neither. Current flows left to right along a row. The last cell of a row feeds the first cell of the next row, so a rung longer than one row simply continues downward. A cell can also be marked as the start of a rung, and then it takes its left input from the power rail.

Software loads cells one at a time through a write port, drives the input image and pulses `start`. The cell outputs are kept in registers and all cells are recomputed together on every clock, starting from all zero. `done` rises when an iteration changes nothing, or after CELLS iterations at most. The settled cell outputs then remain on `coil` until the next start.

Top module: `ladder_grid_eval`

## Requirements
- R1: After reset every cell holds kind code 0 with select 0 and no rung-start mark, and `coil`, `busy` and `done` are all 0.
- R2: The clock edge that samples `start` high clears `coil`, sets `busy` and clears `done`.
- R3: A cell conducts horizontally when its contact is closed and its left input is 1. The left input is the power rail (1) for cell 0 and for any cell with the rung-start mark, and otherwise the output of cell i-1. This makes column 0 of a row continue from the last cell of the row above.
- R4: The kind code is 3 bits. Bit 2 selects a normally-closed contact, which inverts image bit `sel`; with bit 2 at 0 the image bit is used unchanged.
- R5: When kind bit 0 is set (codes 1, 3, 5, 7), cell i is also driven by the output of cell i-COLS. Row 0 gets nothing from this term.
- R6: When kind bit 1 is set (codes 2, 3, 6, 7), cell i is also driven by the output of cell i+COLS-1 ANDed with the contact of cell i+COLS. The bottom row gets nothing from this term.
- R7: Each busy cycle applies one iteration. When an iteration leaves `coil` unchanged, `done` rises and `busy` falls, and `coil` then holds the least fixed point. `done` and `coil` hold until the next start.
- R8: No run takes more than CELLS iterations. After that many iterations `done` rises even if the outputs are still changing.
- R9: While busy, no `coil` bit ever falls from one cycle to the next.
- R10: A configuration write changes only the cell given by `cfg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Cell configuration write strobe |
| cfg_addr | input | 8 | Cell number, row*COLS+column |
| cfg_kind | input | 3 | Kind code: bit 2 normally closed, bit 1 link from below, bit 0 link from above |
| cfg_sel | input | 8 | Input image bit read by the contact |
| cfg_rail | input | 1 | Rung-start mark: the left input comes from the rail |
| img | input | 256 | Input image |
| start | input | 1 | Begin a solve |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | Solution available on coil |
| coil | output | 256 | Cell outputs |

## Verification
The hardest case to reach is the iteration cap. It needs a flow whose outputs keep changing for all CELLS iterations. The stimulus leaves every cell at its reset configuration, with all contacts reading image bit 0, and sets that bit to 1. Power then travels one cell per clock through all 256 cells, wrapping across every row, so only the cap ends the run. A second hard case is current that enters a cell from the row below, which depends on two cells that are themselves settling. A small bypass network with a deliberately open main contact builds this case, and the bench compares every cycle against a behavioural model.

// File: rtl/ladder_pkg.sv
// Shared kind-code layout for the ladder grid evaluator.
// Assumes: a cell kind is 3 bits; the field positions below are decoded
// by the cell evaluator and set by software.
package ladder_pkg;
    localparam int KIND_W   = 3;
    localparam int K_UP_BIT = 0;   // current may enter from the cell above
    localparam int K_DN_BIT = 1;   // current may enter from the cell below
    localparam int K_NC_BIT = 2;   // normally-closed contact
    typedef logic [KIND_W-1:0] kind_t;
endpackage

// File: rtl/ladder_cfg_store.sv
// Holds per-cell kind, image select and rung-start mark.
// Assumes: one write per cycle; reset returns every cell to an open,
// unbranched contact reading image bit 0.
module ladder_cfg_store
    import ladder_pkg::*;
#(
    parameter int CELLS  = 256,
    parameter int ADDR_W = 8,
    parameter int SEL_W  = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            addr,
    input  kind_t                        kind,
    input  logic [SEL_W-1:0]             sel,
    input  logic                         rail,
    output kind_t [CELLS-1:0]            kind_q,
    output logic  [CELLS-1:0][SEL_W-1:0] sel_q,
    output logic  [CELLS-1:0]            rail_q
);
    for (genvar i = 0; i < CELLS; i++) begin : g_cell
        // Per-cell register: load when this cell is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                kind_q[i] <= '0;
                sel_q[i]  <= '0;
                rail_q[i] <= 1'b0;
            end else if (we && addr == ADDR_W'(i)) begin
                kind_q[i] <= kind;
                sel_q[i]  <= sel;
                rail_q[i] <= rail;
            end
        end
    end
endmodule

// File: rtl/ladder_cell_eval.sv
// Combinational next-state of every grid cell from the present outputs.
// Assumes: row-major numbering, COLS cells per row; out-of-grid terms are 0.
module ladder_cell_eval
    import ladder_pkg::*;
#(
    parameter int CELLS = 256,
    parameter int COLS  = 16,
    parameter int SEL_W = 8,
    parameter int IMG_W = 256
) (
    input  logic  [CELLS-1:0]            lo,
    input  kind_t [CELLS-1:0]            kind_q,
    input  logic  [CELLS-1:0][SEL_W-1:0] sel_q,
    input  logic  [CELLS-1:0]            rail_q,
    input  logic  [IMG_W-1:0]            img,
    output logic  [CELLS-1:0]            nxt
);
    logic [CELLS-1:0] hi, up_en, dn_en;
    logic [CELLS-1:0] left_in, from_above, below_left, hi_below;

    for (genvar i = 0; i < CELLS; i++) begin : g_contact
        // Contact state and branch enables decoded from the cell kind.
        assign hi[i]    = img[sel_q[i]] ^ kind_q[i][K_NC_BIT];
        assign up_en[i] = kind_q[i][K_UP_BIT];
        assign dn_en[i] = kind_q[i][K_DN_BIT];
    end

    // Neighbour views: shifts bring in zeros at the grid edges.
    assign left_in    = {lo[CELLS-2:0], 1'b1} | rail_q;
    assign from_above = lo << COLS;
    assign below_left = lo >> (COLS - 1);
    assign hi_below   = hi >> COLS;

    // Cell equation: series path, link from above, link from below.
    assign nxt = (left_in & hi)
               | (up_en & from_above)
               | (dn_en & below_left & hi_below);
endmodule

// File: rtl/ladder_iter_ctrl.sv
// Holds the cell outputs and runs the fixed-point iteration.
// Assumes: configuration and image are steady while busy.
module ladder_iter_ctrl #(
    parameter int CELLS    = 256,
    parameter int MAX_ITER = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CELLS-1:0] nxt,
    output logic [CELLS-1:0] lo,
    output logic             busy,
    output logic             done
);
    localparam int CNT_W = (MAX_ITER > 1) ? $clog2(MAX_ITER) : 1;
    logic [CNT_W-1:0] iter_cnt;

    // Clear on start, then apply iterations until stable or capped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo       <= '0;
            busy     <= 1'b0;
            done     <= 1'b0;
            iter_cnt <= '0;
        end else if (start) begin
            lo       <= '0;
            busy     <= 1'b1;
            done     <= 1'b0;
            iter_cnt <= '0;
        end else if (busy) begin
            if (nxt == lo) begin
                busy <= 1'b0;
                done <= 1'b1;
            end else begin
                lo <= nxt;
                if (iter_cnt == CNT_W'(MAX_ITER - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    iter_cnt <= iter_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ladder_grid_eval.sv
// Ladder contact grid evaluator: configurable cells, iterative power flow.
// Assumes: start is a single-cycle pulse; no configuration writes or image
// changes while busy.
module ladder_grid_eval
    import ladder_pkg::*;
#(
    parameter int  ROWS     = 16,
    parameter int  COLS     = 16,
    parameter int  SEL_W    = 8,
    localparam int CELLS    = ROWS * COLS,
    localparam int ADDR_W   = $clog2(CELLS),
    localparam int IMG_W    = 1 << SEL_W,
    localparam int MAX_ITER = CELLS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [2:0]        cfg_kind,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic              cfg_rail,
    input  logic [IMG_W-1:0]  img,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic [CELLS-1:0]  coil
);
    kind_t [CELLS-1:0]            kind_q;
    logic  [CELLS-1:0][SEL_W-1:0] sel_q;
    logic  [CELLS-1:0]            rail_q;
    logic  [CELLS-1:0]            nxt;

    ladder_cfg_store #(.CELLS(CELLS), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .kind(cfg_kind), .sel(cfg_sel), .rail(cfg_rail),
        .kind_q(kind_q), .sel_q(sel_q), .rail_q(rail_q)
    );

    ladder_cell_eval #(.CELLS(CELLS), .COLS(COLS), .SEL_W(SEL_W), .IMG_W(IMG_W)) u_eval (
        .lo(coil), .kind_q(kind_q), .sel_q(sel_q), .rail_q(rail_q),
        .img(img), .nxt(nxt)
    );

    ladder_iter_ctrl #(.CELLS(CELLS), .MAX_ITER(MAX_ITER)) u_iter (
        .clk(clk), .rst_n(rst_n), .start(start), .nxt(nxt),
        .lo(coil), .busy(busy), .done(done)
    );
endmodule

// File: rtl/ladder_grid_chk.sv
// Protocol and progress checks for ladder_grid_eval, attached by bind.
module ladder_grid_chk #(
    parameter int CELLS    = 256,
    parameter int MAX_ITER = 256
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [CELLS-1:0] coil
);
    localparam int RW = $clog2(MAX_ITER + 1) + 1;
    logic [RW-1:0] run_len;

    // Busy-cycle counter for the iteration-cap window.
    always_ff @(posedge clk) begin
        if (!rst_n || start) run_len <= '0;
        else if (busy)       run_len <= run_len + 1'b1;
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (coil == '0 && !busy && !done));
    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (coil == '0 && busy && !done));
    a_r7_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(coil)));
    a_r8_iter_cap: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_len < RW'(MAX_ITER)));
    a_r9_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start) |=> ((coil & $past(coil)) == $past(coil)));
endmodule

bind ladder_grid_eval ladder_grid_chk #(.CELLS(CELLS), .MAX_ITER(MAX_ITER)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .coil(coil)
);

// File: tb/sim_ladder_grid_eval.sv
module sim_ladder_grid_eval;
    localparam int CLK_PERIOD = 10;
    localparam int N = 256;

    logic clk = 0, rst_n = 0;
    logic cfg_we = 0, cfg_rail = 0, start = 0;
    logic [7:0] cfg_addr = 0, cfg_sel = 0;
    logic [2:0] cfg_kind = 0;
    logic [255:0] img = '0;
    logic busy, done;
    logic [255:0] coil;

    int n_chk = 0, n_bad = 0, cyc = 0;

    // Behavioural model state
    bit [2:0] m_kind [N];
    int       m_sel  [N];
    bit       m_rail [N];
    logic [255:0] m_lo;
    bit m_busy, m_done;
    int m_cnt;

    ladder_grid_eval u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_kind(cfg_kind), .cfg_sel(cfg_sel), .cfg_rail(cfg_rail),
        .img(img), .start(start), .busy(busy), .done(done), .coil(coil)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [255:0] model_step(logic [255:0] lo);
        logic [255:0] r, h;
        for (int i = 0; i < N; i++) h[i] = img[m_sel[i]] ^ m_kind[i][2];
        for (int i = 0; i < N; i++) begin
            bit lft, v;
            lft = (i == 0 || m_rail[i]) ? 1'b1 : lo[i-1];
            v = lft & h[i];
            if (i >= 16 && m_kind[i][0] && lo[i-16]) v = 1;
            if (i < 240 && m_kind[i][1] && lo[i+15] && h[i+16]) v = 1;
            r[i] = v;
        end
        return r;
    endfunction

    // Reference model advanced on each clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin m_kind[i] = 0; m_sel[i] = 0; m_rail[i] = 0; end
            m_lo = '0; m_busy = 0; m_done = 0; m_cnt = 0;
        end else begin
            if (start) begin
                m_lo = '0; m_busy = 1; m_done = 0; m_cnt = 0;
            end else if (m_busy) begin
                logic [255:0] nx;
                nx = model_step(m_lo);
                if (nx == m_lo) begin m_busy = 0; m_done = 1; end
                else begin
                    m_lo = nx; m_cnt++;
                    if (m_cnt == N) begin m_busy = 0; m_done = 1; end
                end
            end
            if (cfg_we) begin
                m_kind[cfg_addr] = cfg_kind; m_sel[cfg_addr] = cfg_sel; m_rail[cfg_addr] = cfg_rail;
            end
        end
    end

    task automatic check(bit ok, string tag, logic [255:0] act, logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the model (R7, R9)
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            check(coil == m_lo, "R7 cycle coil", coil, m_lo);
            check(busy == m_busy && done == m_done, "R7 cycle busy/done",
                  {254'd0, busy, done}, {254'd0, m_busy, m_done});
        end
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic wr(int a, int k, int s, bit r);
        @(negedge clk);
        cfg_we = 1; cfg_addr = 8'(a); cfg_kind = 3'(k); cfg_sel = 8'(s); cfg_rail = r;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic run(output int busy_cycles);
        busy_cycles = 0;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        check(coil == '0 && busy && !done, "R2 start clears", coil, '0);
        while (busy) begin
            busy_cycles++;
            @(negedge clk);
        end
        check(done, "R7 done raised", {255'd0, done}, 256'd1);
    endtask

    initial begin
        int bc;
        logic [255:0] exp;
        repeat (3) @(negedge clk);
        check(coil == '0 && !busy && !done, "R1 reset state", coil, '0);
        rst_n = 1;
        @(negedge clk);

        // Default cells all read bit 0: flow snakes through every row (R3, R8)
        img = 256'd1;
        run(bc);
        check(coil == '1, "R3 wrap chain", coil, '1);
        check(bc == 256, "R8 iteration cap", 256'(bc), 256'd256);
        repeat (3) @(negedge clk);
        check(done && coil == '1, "R7 result held", coil, '1);

        img = '0;
        run(bc);
        check(coil == '0, "R3 open contacts", coil, '0);
        check(bc == 1, "R7 early stop", 256'(bc), 256'd1);

        // Normally closed cell 0 (R4, R10)
        wr(0, 4, 0, 0);
        run(bc);
        check(coil == 256'd1, "R4 NC cell0 / R10 single cell", coil, 256'd1);
        check(bc == 2, "R7 stop after 2", 256'(bc), 256'd2);

        for (int i = 0; i < N; i++) wr(i, 4, 0, 0);
        run(bc);
        check(coil == '1, "R4 all NC closed", coil, '1);

        // Bypass network (R5, R6)
        for (int i = 0; i < N; i++) wr(i, 0, 1, 0);
        wr(0, 0, 0, 0);
        wr(1, 2, 2, 0);
        wr(2, 0, 0, 0);
        wr(5, 3, 0, 0);
        wr(16, 0, 0, 1);
        wr(17, 0, 0, 0);
        wr(33, 1, 1, 0);
        img = 256'd1;
        run(bc);
        exp = '0; exp[0] = 1; exp[1] = 1; exp[2] = 1; exp[16] = 1; exp[17] = 1; exp[33] = 1;
        check(coil == exp, "R6 link from below / R5 link from above", coil, exp);
        check(coil[5] == 0, "R5 row0 no above", coil, exp);

        wr(2, 0, 1, 0);
        run(bc);
        exp[2] = 0;
        check(coil == exp, "R10 rewrite cell2 only", coil, exp);

        // Bottom row: link from below has nothing to draw on (R6)
        wr(240, 0, 0, 1);
        wr(241, 2, 1, 0);
        run(bc);
        exp[240] = 1;
        check(coil == exp, "R6 bottom row", coil, exp);

        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule